// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns stereo PCM sample pairs into a single serial data line for an audio codec. An external clock generator supplies a one-cycle pulse, `bit_tick`, for every launch edge of the bit clock, which is the edge opposite the one the codec samples on. It also supplies the channel indicator `chan_sel`, where 0 means left and 1 means right. The block keeps track of the bit position inside each channel slot. It places each sample in its slot according to the format chosen at run time. Every bit period that carries no sample bit is driven low.

Three framings are supported. In the first, the most significant bit (MSB) is delayed by one bit after the channel change, as in standard I2S. In left-justified framing the MSB comes on the change itself. In right-justified framing the least significant bit (LSB) fills the final bit of the slot. The word length can be 16, 24 or 32 bits. Each channel slot is `SLOT_BITS` bit periods long and must be longer than 32 bits.

Samples arrive as whole pairs on a valid/ready handshake. The pair goes into a one-pair holding register. At the start of each frame the holding register is copied into the active pair. If no pair is waiting when a frame starts, the frame is sent as zeros and a sticky underrun flag is raised.

Top module: `stereo_serializer`

## Requirements
- R1: After reset, `sdata` is 0, `underrun` is 0 and `in_ready` is 1.
- R2: A pair is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the next frame start that has both enables set moves the pair out of the holding register.
- R3: A frame starts on a `bit_tick` where `chan_sel` is 0 and the previous tick had `chan_sel` 1. After reset, the first tick with `chan_sel` 0 also counts as a frame start. The left slot is every tick with `chan_sel` 0 and the right slot every tick with `chan_sel` 1. Slot position 0 is the first tick of a slot. The left sample is sent in the left slot and the right sample in the right slot.
- R4: With `rjust`=0 and `msb_delay`=0, the word is sent MSB first, starting at slot position 0.
- R5: With `rjust`=0 and `msb_delay`=1, the MSB is at slot position 1 and position 0 carries 0.
- R6: With `rjust`=1, the LSB is at slot position `SLOT_BITS`-1 and `msb_delay` has no effect.
- R7: `wlen_sel` selects the word length: 0 means 16 bits, 1 means 24 bits, 2 means 32 bits, and 3 is treated as 32 bits. The word is taken from the low bits of `in_left` and `in_right`.
- R8: Every slot position that carries no sample bit is driven as 0.
- R9: If a frame starts with both enables set and the holding register empty, both slots of that frame carry zeros. `underrun` then goes to 1 and stays at 1 until a cycle with `underrun_clr` high.
- R10: A frame carries data only if `core_en` and `tx_en` are both 1 at its start. Otherwise the frame is all zeros, any waiting pair stays in the holding register, and `underrun` is not raised.
- R11: `sdata` changes only in the cycle after a `bit_tick`. The format, word length and enables are sampled at frame start, so changing them mid-frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit-clock launch edge |
| chan_sel | input | 1 | Channel indicator: 0 = left, 1 = right |
| core_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit-path enable |
| wlen_sel | input | 2 | Word length code |
| rjust | input | 1 | Right-justify the word in its slot |
| msb_delay | input | 1 | Delay the MSB by one bit (left-aligned only) |
| in_left | input | 32 | Left sample, LSB-aligned |
| in_right | input | 32 | Right sample, LSB-aligned |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | Holding register is empty |
| underrun_clr | input | 1 | Clears the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| sdata | output | 1 | Serial data output |

## Verification
The assertions assume that `chan_sel` changes only together with a `bit_tick`. They also assume that each slot is exactly `SLOT_BITS` ticks long, with no position counted past the end. The bench drives its ticks and channel changes from a single frame task that follows both rules. All other inputs change on the falling clock edge. The holding register is filled only between frames. Configuration is changed mid-frame only deliberately, to show that it has no effect.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int unsigned SAMPLE_W = 32;

  typedef enum logic [1:0] {
    WL16  = 2'd0,
    WL24  = 2'd1,
    WL32  = 2'd2,
    WL32X = 2'd3
  } wlen_e;

  function automatic int unsigned word_bits(input wlen_e wl);
    case (wl)
      WL16:    return 16;
      WL24:    return 24;
      default: return 32;
    endcase
  endfunction

  // Bit of sample d at slot position pos, given format and slot length.
  function automatic logic pick_bit(input logic [SAMPLE_W-1:0] d,
                                    input int unsigned pos,
                                    input wlen_e wl,
                                    input logic rj,
                                    input logic dly,
                                    input int unsigned slot);
    int unsigned w;
    int unsigned s;
    logic [4:0]  idx;
    logic        res;
    w = word_bits(wl);
    s = rj ? (slot - w) : 32'(dly);
    res = 1'b0;
    if ((pos >= s) && (pos < s + w)) begin
      idx = 5'(w - 1 - (pos - s));
      res = d[idx];
    end
    return res;
  endfunction

endpackage

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int SLOT_BITS = 40,
  localparam int PW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          chan_sel,
  output logic          frame_start,
  output logic [PW-1:0] pos_now
);

  logic          last_q;
  logic [PW-1:0] pos_q;

  assign frame_start = bit_tick && !chan_sel && last_q;

  always_comb begin
    if (chan_sel != last_q)
      pos_now = '0;
    else if (pos_q == PW'(SLOT_BITS - 1))
      pos_now = pos_q;
    else
      pos_now = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      pos_q  <= PW'(SLOT_BITS - 1);
    end else if (bit_tick) begin
      last_q <= chan_sel;
      pos_q  <= pos_now;
    end
  end

  // R3
  pos_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && (chan_sel != last_q)) |=> (pos_q == '0));

endmodule

// File: rtl/pair_holder.sv
module pair_holder
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  input  logic                take,
  input  logic                underrun_clr,
  output logic [SAMPLE_W-1:0] nxt_l,
  output logic [SAMPLE_W-1:0] nxt_r,
  output logic [SAMPLE_W-1:0] act_l,
  output logic [SAMPLE_W-1:0] act_r,
  output logic                underrun
);

  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic                hold_full;

  assign in_ready = !hold_full;
  assign nxt_l    = hold_full ? hold_l : '0;
  assign nxt_r    = hold_full ? hold_r : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l    <= '0;
      hold_r    <= '0;
      hold_full <= 1'b0;
      act_l     <= '0;
      act_r     <= '0;
      underrun  <= 1'b0;
    end else begin
      if (underrun_clr)
        underrun <= 1'b0;
      if (take) begin
        act_l <= nxt_l;
        act_r <= nxt_r;
        if (hold_full)
          hold_full <= 1'b0;
        else
          underrun <= 1'b1;
      end
      if (in_valid && !hold_full) begin
        hold_l    <= in_left;
        hold_r    <= in_right;
        hold_full <= 1'b1;
      end
    end
  end

  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !take) |=> !in_ready);

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun);

  // R9
  underrun_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_ready) |=> underrun);

endmodule

// File: rtl/stereo_serializer.sv
module stereo_serializer
  import sertx_pkg::*;
#(
  parameter int SLOT_BITS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_tick,
  input  logic                chan_sel,
  input  logic                core_en,
  input  logic                tx_en,
  input  logic [1:0]          wlen_sel,
  input  logic                rjust,
  input  logic                msb_delay,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                underrun_clr,
  output logic                underrun,
  output logic                sdata
);

  localparam int PW = $clog2(SLOT_BITS);

  logic                frame_start;
  logic [PW-1:0]       pos_now;
  logic [SAMPLE_W-1:0] nxt_l, nxt_r, act_l, act_r;
  logic                run_next, take;

  logic                run_q;
  wlen_e               wl_q;
  logic                rj_q, dly_q;
  logic                sdata_q;

  assign run_next = core_en && tx_en;
  assign take     = frame_start && run_next;
  assign sdata    = sdata_q;

  slot_tracker #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .chan_sel    (chan_sel),
    .frame_start (frame_start),
    .pos_now     (pos_now)
  );

  pair_holder u_hold (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_left      (in_left),
    .in_right     (in_right),
    .in_ready     (in_ready),
    .take         (take),
    .underrun_clr (underrun_clr),
    .nxt_l        (nxt_l),
    .nxt_r        (nxt_r),
    .act_l        (act_l),
    .act_r        (act_r),
    .underrun     (underrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      wl_q    <= WL16;
      rj_q    <= 1'b0;
      dly_q   <= 1'b0;
      sdata_q <= 1'b0;
    end else if (bit_tick) begin
      if (frame_start) begin
        run_q   <= run_next;
        wl_q    <= wlen_e'(wlen_sel);
        rj_q    <= rjust;
        dly_q   <= msb_delay;
        sdata_q <= run_next &&
                   pick_bit(nxt_l, 0, wlen_e'(wlen_sel), rjust, msb_delay,
                            SLOT_BITS);
      end else begin
        sdata_q <= run_q &&
                   pick_bit(chan_sel ? act_r : act_l, 32'(pos_now), wl_q,
                            rj_q, dly_q, SLOT_BITS);
      end
    end
  end

  // R11
  quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(sdata));

  // R10
  idle_frame_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (sdata == 1'b0));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> (sdata == 1'b0 && underrun == 1'b0));

endmodule

// File: tb/stereo_serializer_test.sv
module stereo_serializer_test;

  localparam int SLOT = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        chan_sel = 1'b1;
  logic        core_en = 1'b1;
  logic        tx_en = 1'b1;
  logic [1:0]  wlen_sel = 2'd0;
  logic        rjust = 1'b0;
  logic        msb_delay = 1'b0;
  logic [31:0] in_left = '0;
  logic [31:0] in_right = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        underrun_clr = 1'b0;
  logic        underrun;
  logic        sdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [SLOT-1:0] cap_l, cap_r;

  always #2.5 clk = ~clk;

  stereo_serializer #(.SLOT_BITS(SLOT)) uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .chan_sel(chan_sel),
    .core_en(core_en), .tx_en(tx_en), .wlen_sel(wlen_sel), .rjust(rjust),
    .msb_delay(msb_delay), .in_left(in_left), .in_right(in_right),
    .in_valid(in_valid), .in_ready(in_ready), .underrun_clr(underrun_clr),
    .underrun(underrun), .sdata(sdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected slot contents from the framing rules (R4..R8).
  function automatic logic [SLOT-1:0] exp_slot(input logic [31:0] d, input int wl,
                                               input logic rj, input logic dly);
    logic [SLOT-1:0] v;
    int w;
    int first;
    w = (wl == 0) ? 16 : (wl == 1) ? 24 : 32;
    first = rj ? SLOT - w : int'(dly);
    v = '0;
    for (int k = 0; k < w; k++) v[first + k] = d[w - 1 - k];
    return v;
  endfunction

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    in_left = l; in_right = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // One frame: SLOT ticks left then SLOT ticks right, capturing sdata.
  task automatic run_frame(input bit midflip);
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < SLOT; p++) begin
        @(negedge clk);
        chan_sel = ch[0]; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        if (ch == 0) cap_l[p] = sdata; else cap_r[p] = sdata;
        if (midflip && ch == 0 && p == 3) begin
          rjust = ~rjust; wlen_sel = 2'd2; msb_delay = ~msb_delay;
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R11 hold without tick", 64'(sdata), 64'(cap_l[3]));
          end
        end
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sdata", 64'(sdata), 64'd0);
    check("R1 underrun", 64'(underrun), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_left16;
    wlen_sel = 2'd0; rjust = 1'b0; msb_delay = 1'b0;
    push(32'h1234_A5C3, 32'h0000_F00D);
    check("R2 ready low while held", 64'(in_ready), 64'd0);
    run_frame(1'b0);
    check("R4 R3 R8 left16 left", 64'(cap_l), 64'(exp_slot(32'h1234_A5C3, 0, 0, 0)));
    check("R4 R3 R7 left16 right", 64'(cap_r), 64'(exp_slot(32'h0000_F00D, 0, 0, 0)));
    check("R2 ready after frame start", 64'(in_ready), 64'd1);
    check("R9 no underrun", 64'(underrun), 64'd0);
  endtask

  task automatic t_i2s24;
    wlen_sel = 2'd1; rjust = 1'b0; msb_delay = 1'b1;
    push(32'hFF96_3C5A, 32'h00C3_0F81);
    run_frame(1'b0);
    check("R5 R7 i2s24 left", 64'(cap_l), 64'(exp_slot(32'hFF96_3C5A, 1, 0, 1)));
    check("R5 R7 i2s24 right", 64'(cap_r), 64'(exp_slot(32'h00C3_0F81, 1, 0, 1)));
  endtask

  task automatic t_right32;
    wlen_sel = 2'd2; rjust = 1'b1; msb_delay = 1'b1;
    push(32'h8000_0001, 32'hDEAD_BEEF);
    run_frame(1'b0);
    check("R6 right32 left", 64'(cap_l), 64'(exp_slot(32'h8000_0001, 2, 1, 0)));
    check("R6 right32 right", 64'(cap_r), 64'(exp_slot(32'hDEAD_BEEF, 2, 1, 0)));
  endtask

  task automatic t_right16_code3;
    wlen_sel = 2'd0; rjust = 1'b1; msb_delay = 1'b0;
    push(32'hFFFF_8001, 32'h0000_7FFE);
    run_frame(1'b0);
    check("R6 R8 right16 left", 64'(cap_l), 64'(exp_slot(32'hFFFF_8001, 0, 1, 0)));
    check("R6 R8 right16 right", 64'(cap_r), 64'(exp_slot(32'h0000_7FFE, 0, 1, 0)));
    wlen_sel = 2'd3; rjust = 1'b0; msb_delay = 1'b0;
    push(32'hC001_0203, 32'h4000_0002);
    run_frame(1'b0);
    check("R7 code3 as 32 left", 64'(cap_l), 64'(exp_slot(32'hC001_0203, 2, 0, 0)));
    check("R7 code3 as 32 right", 64'(cap_r), 64'(exp_slot(32'h4000_0002, 2, 0, 0)));
  endtask

  task automatic t_underrun;
    wlen_sel = 2'd0; rjust = 1'b0; msb_delay = 1'b0;
    run_frame(1'b0);
    check("R9 starved left zero", 64'(cap_l), 64'd0);
    check("R9 starved right zero", 64'(cap_r), 64'd0);
    check("R9 flag raised", 64'(underrun), 64'd1);
    push(32'h0000_ABCD, 32'h0000_1357);
    run_frame(1'b0);
    check("R9 data after underrun", 64'(cap_l), 64'(exp_slot(32'h0000_ABCD, 0, 0, 0)));
    check("R9 flag sticky", 64'(underrun), 64'd1);
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    check("R9 flag cleared", 64'(underrun), 64'd0);
  endtask

  task automatic t_enable;
    wlen_sel = 2'd0; rjust = 1'b0; msb_delay = 1'b0;
    tx_en = 1'b0;
    push(32'h0000_9AB1, 32'h0000_6E27);
    run_frame(1'b0);
    check("R10 disabled left zero", 64'(cap_l), 64'd0);
    check("R10 disabled right zero", 64'(cap_r), 64'd0);
    check("R10 pair kept", 64'(in_ready), 64'd0);
    check("R10 no underrun", 64'(underrun), 64'd0);
    tx_en = 1'b1; core_en = 1'b0;
    run_frame(1'b0);
    check("R10 core off zero", 64'(cap_l), 64'd0);
    core_en = 1'b1;
    run_frame(1'b0);
    check("R10 kept pair left", 64'(cap_l), 64'(exp_slot(32'h0000_9AB1, 0, 0, 0)));
    check("R10 kept pair right", 64'(cap_r), 64'(exp_slot(32'h0000_6E27, 0, 0, 0)));
  endtask

  task automatic t_midcfg;
    wlen_sel = 2'd0; rjust = 1'b0; msb_delay = 1'b0;
    push(32'h0000_C3A5, 32'h0000_5A3C);
    run_frame(1'b1);
    check("R11 mid-frame cfg left", 64'(cap_l), 64'(exp_slot(32'h0000_C3A5, 0, 0, 0)));
    check("R11 mid-frame cfg right", 64'(cap_r), 64'(exp_slot(32'h0000_5A3C, 0, 0, 0)));
  endtask

  initial begin
    t_reset();
    t_left16();
    t_i2s24();
    t_right32();
    t_right16_code3();
    t_underrun();
    t_enable();
    t_midcfg();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule